// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a free-running clock source and a group of clock outputs. It gates each output with two controls. The first is a per-output enable bit that comes from a configuration register. The second is a group-wide, active-low stop request that arrives asynchronously. The stop request passes through a synchronizer in the clock's own domain. Every gating decision is registered on the falling clock edge, so an output can only start or stop while the clock is low. A stopped output therefore always rests at logic low, and the first pulse after a restart has its full high width.

A strap input selects the operating mode and is captured once, on the first clock after reset. In mobile mode (strap = 0) the stop request is honoured. In desktop mode (strap = 1) the pin is not a stop input, so the block treats the request as released. A chip uses one instance per clock group, each with its own parameters. The processor group uses a two-stage synchronizer and needs at least 100 cycles between stops. The peripheral-bus group uses a single stage and needs at least 10 cycles.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit is low, whatever the values of `out_en` and `stop_n`.
- R2: In mobile mode, after `stop_n` goes low, each enabled output gives exactly SYNC_STAGES more high pulses. These fall on the next SYNC_STAGES rising edges of `clk_in`. From then on the output stays low for as long as `stop_n` stays low.
- R3: Every high pulse on a `clk_out` bit lasts a full high phase of `clk_in`. There are no shortened or extra pulses, and this holds through stops, restarts and enable changes.
- R4: In mobile mode, after `stop_n` returns high, an enabled output stays low for SYNC_STAGES rising edges. Its first high pulse comes on the rising edge SYNC_STAGES+1 after the release.
- R5: In desktop mode, `stop_n` has no effect: every enabled output keeps toggling while `stop_n` is low.
- R6: `mode_strap` is sampled once, on the first clock after reset is released internally. Later changes to `mode_strap` have no effect until the next reset.
- R7: An output whose `out_en` bit is 0 stays low. A change of an `out_en` bit reaches its own output on the next rising edge of `clk_in` and leaves the other outputs alone.
- R8: In mobile mode, `stop_n` must stay high for at least MIN_RUN clock cycles between two stop requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_strap | input | 1 | Mode strap: 0 selects mobile (stop honoured), 1 selects desktop |
| stop_n | input | 1 | Asynchronous active-low stop request for the whole group |
| out_en | input | NUM_OUT | Per-output enable from the register, 1 lets the output run |
| clk_out | output | NUM_OUT | Gated clock outputs, parked low when stopped or disabled |

## Verification
The bench sweeps every enable pattern in both strap modes. It counts the surviving pulses after a stop and the missing pulses after a release, for two synchronizer depths at once. A design that sampled the request without a synchronizer, or with one stage too many, would show up as an off-by-one count in one of the two instances. A design that gated the clock on the rising edge would cut the high phase short. A width monitor on the outputs catches this, including at restart and at reset entry. The bench flips the strap after it has been captured; a design that kept following the pin would start honouring or ignoring the stop halfway through a run.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Operating mode captured from the strap input
  typedef enum logic {
    MODE_MOBILE  = 1'b0,
    MODE_DESKTOP = 1'b1
  } strap_mode_e;
endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage synchronizer with a selectable reset value.
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_strap.sv
// Captures the mode strap once after reset and holds it.
module clkstop_strap
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap,
  output strap_mode_e mode_q,
  output logic        mode_vld
);
  strap_mode_e mode_d;
  logic        vld_d;

  always_comb begin
    mode_d = mode_q;
    vld_d  = mode_vld;
    if (!mode_vld) begin
      mode_d = strap_mode_e'(strap);
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_MOBILE;
      mode_vld <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      mode_vld <= vld_d;
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
// One gated output: enable registered on the falling edge, so it
// only changes while the clock is low.
module clkstop_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic gclk
);
  logic en_d;
  logic en_q;

  always_comb begin
    en_d = en & run;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               mode_strap,
  input  logic               stop_n,
  input  logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] clk_out
);
  logic        rst_int_n;
  logic        stop_sync;
  strap_mode_e mode_q;
  logic        mode_vld;
  logic        desk_mode;
  logic        run;

  // reset: asserted at once, released after RST_STAGES rising edges
  clkstop_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk_in),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  // stop request into the clock domain; idles as "running"
  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk   (clk_in),
    .rst_n (rst_int_n),
    .d     (stop_n),
    .q     (stop_sync)
  );

  clkstop_strap u_strap (
    .clk      (clk_in),
    .rst_n    (rst_int_n),
    .strap    (mode_strap),
    .mode_q   (mode_q),
    .mode_vld (mode_vld)
  );

  always_comb begin
    desk_mode = (mode_q == MODE_DESKTOP);
    run       = desk_mode | stop_sync;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    clkstop_lane u_lane (
      .clk   (clk_in),
      .rst_n (rst_int_n),
      .run   (run),
      .en    (out_en[g]),
      .gclk  (clk_out[g])
    );
  end
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input logic               clk_in,
  input logic               rst_n,
  input logic               stop_n,
  input logic [NUM_OUT-1:0] out_en,
  input logic [NUM_OUT-1:0] clk_out,
  input logic               desk_mode,
  input logic               mode_vld
);
  localparam int HOLD = SYNC_STAGES + 2;
  localparam int LW   = $clog2(HOLD + 1);
  localparam int RW   = $clog2(MIN_RUN + 1);

  logic [LW-1:0] lo_cnt;
  logic [RW-1:0] hi_cnt;

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= RW'(MIN_RUN);
    end else begin
      if (stop_n) lo_cnt <= '0;
      else if (lo_cnt != LW'(HOLD)) lo_cnt <= lo_cnt + 1'b1;
      if (!stop_n) hi_cnt <= '0;
      else if (hi_cnt != RW'(MIN_RUN)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    // R7
    gate_off_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      !$past(out_en[i]) |-> !clk_out[i]);

    // R5
    desk_run_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      (mode_vld && desk_mode && $past(mode_vld) && $past(out_en[i])) |-> clk_out[i]);
  end

  // R2
  stop_park_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    (mode_vld && !desk_mode && lo_cnt == LW'(HOLD)) |-> (clk_out == '0));

  // R8
  run_win_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    (mode_vld && !desk_mode && $fell(stop_n)) |-> (hi_cnt == RW'(MIN_RUN)));

  // R6
  strap_hold_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    mode_vld |=> (mode_vld && $stable(desk_mode)));
endmodule

bind clkstop_gate clkstop_gate_chk #(
  .NUM_OUT     (NUM_OUT),
  .SYNC_STAGES (SYNC_STAGES),
  .MIN_RUN     (MIN_RUN)
) u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .stop_n    (stop_n),
  .out_en    (out_en),
  .clk_out   (clk_out),
  .desk_mode (desk_mode),
  .mode_vld  (mode_vld)
);

// File: tb/clkstop_gate_test.sv
`timescale 1ns/1ps
module clkstop_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       stop_n = 1'b1;
  logic [1:0] cpu_en = 2'b11;
  logic [1:0] pci_en = 2'b11;
  logic [1:0] cpu_out;
  logic [1:0] pci_out;

  int n_chk = 0;
  int n_fail = 0;
  int since_rel = 1000;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkstop_gate #(.NUM_OUT(2), .SYNC_STAGES(2), .RST_STAGES(2), .MIN_RUN(100)) uut (
    .clk_in(clk), .rst_n(rst_n), .mode_strap(strap), .stop_n(stop_n),
    .out_en(cpu_en), .clk_out(cpu_out));

  clkstop_gate #(.NUM_OUT(2), .SYNC_STAGES(1), .RST_STAGES(2), .MIN_RUN(10)) uut_pci (
    .clk_in(clk), .rst_n(rst_n), .mode_strap(strap), .stop_n(stop_n),
    .out_en(pci_en), .clk_out(pci_out));

  // R3: every high pulse must last exactly one high phase (4 ns)
  realtime rise_c = 0.0, rise_p = 0.0;
  bit arm_c = 1'b0, arm_p = 1'b0;
  always @(posedge cpu_out[0]) begin rise_c = $realtime; arm_c = 1'b1; end
  always @(negedge cpu_out[0]) if (arm_c) begin
    n_chk++;
    if (($realtime - rise_c) < 3.99 || ($realtime - rise_c) > 4.01) begin
      n_fail++;
      $display("FAIL R3 cpu pulse width: got %0t expected 4ns", $realtime - rise_c);
    end
  end
  always @(posedge pci_out[1]) begin rise_p = $realtime; arm_p = 1'b1; end
  always @(negedge pci_out[1]) if (arm_p) begin
    n_chk++;
    if (($realtime - rise_p) < 3.99 || ($realtime - rise_p) > 4.01) begin
      n_fail++;
      $display("FAIL R3 pci pulse width: got %0t expected 4ns", $realtime - rise_p);
    end
  end

  task automatic smp();
    @(posedge clk);
    #2;
    since_rel++;
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    strap = m;
    repeat (3) smp();
    chk("R1 cpu in reset", cpu_out, 2'b00);
    chk("R1 pci in reset", pci_out, 2'b00);
    rst_n = 1'b1;
    since_rel = 1000;
    repeat (6) smp();
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      cpu_en = 2'b11;
      pci_en = 2'b11;
      do_reset(m[0]);
      strap = ~m[0];  // R6: later strap changes must be ignored
      for (int e = 0; e < 4; e++) begin
        logic [1:0] ev;
        logic       mob;
        ev  = e[1:0];
        mob = (m == 0);
        cpu_en = ev;
        pci_en = ev;
        smp();
        chk("R7 cpu enable", cpu_out, ev);
        chk("R7 pci enable", pci_out, ev);
        n_chk++;
        if (since_rel < 100) begin
          n_fail++;
          $display("FAIL R8 stop spacing: got %0d expected >= 100", since_rel);
        end
        stop_n = 1'b0;
        for (int k = 1; k <= 5; k++) begin
          smp();
          chk(mob ? "R2 cpu stop" : "R5 cpu desktop", cpu_out, (mob && k >= 3) ? 2'b00 : ev);
          chk(mob ? "R2 pci stop" : "R5 pci desktop", pci_out, (mob && k >= 2) ? 2'b00 : ev);
        end
        stop_n = 1'b1;
        since_rel = 0;
        for (int k = 1; k <= 5; k++) begin
          smp();
          chk(mob ? "R4 cpu restart" : "R6 cpu held mode", cpu_out, (mob && k <= 2) ? 2'b00 : ev);
          chk(mob ? "R4 pci restart" : "R6 pci held mode", pci_out, (mob && k <= 1) ? 2'b00 : ev);
        end
        repeat (100) smp();
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule